// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a 16-bit down-counter with an 8-bit register port. Software loads a full-count value into two byte registers. It then sets a run bit in a control register. From that point the counter steps down from the full count toward zero. It steps on every clock cycle or only on cycles that carry a slow-tick strobe, chosen by a source-select bit.

When the counter sits at zero and one more enabled tick arrives, the timer emits a one-cycle terminal pulse. In repeat mode it then reloads the full count and keeps going. In single mode it stops and clears the run bit itself, so software can poll that bit to see completion.

The slow-tick strobe is a single-cycle enable that is already synchronous to the block clock. The whole block lives in one clock domain.

Top module: `interval_timer`

## Requirements
- R1: Register map at `reg_addr`. Address 0 is control: bit 0 RUN, bit 1 SINGLE, bit 2 FAST, and bits 7:3 read as 0. Address 1 holds the full-count low byte and address 2 the high byte, both read/write. Address 3 reads 0 and ignores writes. Every register resets to 0.
- R2: While RUN is 1, the counter steps every cycle when FAST is 1. When FAST is 0 it steps only on cycles with `slow_tick` high.
- R3: Writing control with bit 0 set while RUN is 0 loads the counter with the full count. The terminal tick is the enabled tick that finds the counter at zero. A full count of N therefore gives a terminal pulse after N+1 enabled ticks, and N = 0 gives it on the first enabled tick.
- R4: With SINGLE at 0, the terminal tick reloads the full count and counting continues, so pulses repeat every N+1 enabled ticks.
- R5: With SINGLE at 1, the terminal tick stops the counter and RUN reads back as 0 afterwards.
- R6: `tc_pulse` is high for the one cycle that follows each terminal tick and is low otherwise.
- R7: A control write with bit 0 clear stops the counter at once and produces no pulse, even in a cycle that would have been terminal. A later start counts again from the full count.
- R8: Writing the full-count bytes while running changes only the value used at the next load or reload.
- R9: A control write with bit 0 set while RUN is already 1 does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| slow_tick | input | 1 | Single-cycle slow count enable |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The assertions check several rules on every cycle:
- a pulse only ever follows a running cycle;
- a single-mode pulse always coincides with RUN clearing;
- a repeat-mode pulse coincides with a reload of the previous full count;
- the counter holds when idle or between slow ticks;
- in fast mode it falls by one per cycle;
- a stop write silences the pulse.

The exact pulse spacing for a given full count and tick pattern can only be shown by the bench scenarios. The same holds for the zero-count case, a stop landing on the terminal cycle, mid-run rewrites of the count bytes, and a control rewrite that must not restart the count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int CTRL_ADDR = 0;
  localparam int FULL_BASE = 1;
  localparam int RUN_BIT    = 0;
  localparam int SINGLE_BIT = 1;
  localparam int FAST_BIT   = 2;

  typedef struct packed {
    logic fast;
    logic single;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int BYTES  = 2,
  parameter int AW     = ADDR_W,
  localparam int CNT_W = DATA_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              single_done,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  full,
  output logic              start_load,
  output logic              sw_stop,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_hit;

  assign ctrl_hit   = we && (addr == AW'(CTRL_ADDR));
  assign start_load = ctrl_hit && wdata[RUN_BIT] && !ctrl_q.run;
  assign sw_stop    = ctrl_hit && !wdata[RUN_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_hit) begin
      ctrl_d.fast   = wdata[FAST_BIT];
      ctrl_d.single = wdata[SINGLE_BIT];
      ctrl_d.run    = wdata[RUN_BIT] && !single_done;
    end else if (single_done) begin
      ctrl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      logic [DATA_W-1:0] q, d;
      logic              hit;
      assign hit = we && (addr == AW'(FULL_BASE + b));
      always_comb d = hit ? wdata : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign full[b*DATA_W +: DATA_W] = q;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == AW'(CTRL_ADDR)) begin
      rdata[FAST_BIT]   = ctrl_q.fast;
      rdata[SINGLE_BIT] = ctrl_q.single;
      rdata[RUN_BIT]    = ctrl_q.run;
    end
    for (int b = 0; b < BYTES; b++) begin
      if (addr == AW'(FULL_BASE + b)) rdata = full[b*DATA_W +: DATA_W];
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/timer_tick_sel.sv
module timer_tick_sel (
  input  logic fast,
  input  logic slow_tick,
  output logic tick_en
);
  assign tick_en = fast | slow_tick;
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             single,
  input  logic             tick_en,
  input  logic             start_load,
  input  logic             sw_stop,
  input  logic [CNT_W-1:0] full,
  output logic [CNT_W-1:0] count,
  output logic             single_done,
  output logic             tc_pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc_q, tc_d;
  logic             step, terminal, cnt_en;

  assign step        = run && tick_en && !sw_stop;
  assign terminal    = step && (cnt_q == '0);
  assign single_done = terminal && single;
  assign cnt_en      = start_load || step;

  always_comb begin
    cnt_d = cnt_q;
    if (start_load)      cnt_d = full;
    else if (terminal)   cnt_d = single ? cnt_q : full;
    else if (step)       cnt_d = cnt_q - 1'b1;
    tc_d = terminal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign count    = cnt_q;
  assign tc_pulse = tc_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int BYTES  = 2,
  parameter int AW     = ADDR_W,
  localparam int CNT_W = DATA_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              slow_tick,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tc_pulse
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] full_val, count_val;
  logic             start_load, sw_stop, single_done, tick_en;
  logic             run_bit, single_bit, fast_bit;

  assign run_bit    = ctrl.run;
  assign single_bit = ctrl.single;
  assign fast_bit   = ctrl.fast;

  timer_regs #(.DATA_W(DATA_W), .BYTES(BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .single_done(single_done), .ctrl(ctrl), .full(full_val),
    .start_load(start_load), .sw_stop(sw_stop), .rdata(reg_rdata)
  );

  timer_tick_sel u_tick (
    .fast(fast_bit), .slow_tick(slow_tick), .tick_en(tick_en)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_bit), .single(single_bit),
    .tick_en(tick_en), .start_load(start_load), .sw_stop(sw_stop),
    .full(full_val), .count(count_val), .single_done(single_done),
    .tc_pulse(tc_pulse)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W = 8,
  parameter int AW     = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              slow_tick,
  input logic              tc_pulse,
  input logic              run_bit,
  input logic              single_bit,
  input logic              fast_bit,
  input logic [CNT_W-1:0]  count_val,
  input logic [CNT_W-1:0]  full_val
);
  logic ctrl_wr, stop_wr;
  assign ctrl_wr = reg_we && (reg_addr == '0);
  assign stop_wr = ctrl_wr && !reg_wdata[0];

  AST_TC_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(run_bit)); // R6

  AST_SINGLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && $past(single_bit)) |-> !run_bit); // R5

  AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !$past(single_bit)) |-> (run_bit && count_val == $past(full_val))); // R4

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && !fast_bit && !slow_tick && !reg_we) |=> ($stable(count_val) && !tc_pulse)); // R2

  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && fast_bit && count_val != '0 && !reg_we) |=> (count_val == $past(count_val) - 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_bit && !reg_we) |=> ($stable(count_val) && !tc_pulse)); // R7

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!run_bit && !tc_pulse)); // R7
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .slow_tick(slow_tick), .tc_pulse(tc_pulse),
  .run_bit(run_bit), .single_bit(single_bit), .fast_bit(fast_bit),
  .count_val(count_val), .full_val(full_val)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       slow_tick;
  logic [7:0] reg_rdata;
  logic       tc_pulse;

  int checks;
  int fails;

  logic        m_run, m_single, m_fast, m_tc;
  logic [15:0] m_full, m_cnt;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .slow_tick(slow_tick),
    .reg_rdata(reg_rdata), .tc_pulse(tc_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [1:0] a);
    case (a)
      2'd0:    return {5'b0, m_fast, m_single, m_run};
      2'd1:    return m_full[7:0];
      2'd2:    return m_full[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_update(input logic we, input logic [1:0] a, input logic [7:0] d, input logic t);
    logic cw, stop, load, tk, step, term;
    cw   = we && (a == 2'd0);
    stop = cw && !d[0];
    load = cw && d[0] && !m_run;
    tk   = m_fast || t;
    step = m_run && tk && !stop;
    term = step && (m_cnt == 16'd0);
    m_tc = term;
    if (load) m_cnt = m_full;
    else if (term) m_cnt = m_single ? m_cnt : m_full;
    else if (step) m_cnt = m_cnt - 16'd1;
    if (cw) begin
      m_fast   = d[2];
      m_run    = d[0] && !(term && m_single);
      m_single = d[1];
    end else if (term && m_single) begin
      m_run = 1'b0;
    end
    if (we && a == 2'd1) m_full[7:0]  = d;
    if (we && a == 2'd2) m_full[15:8] = d;
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic t, input string tag);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; slow_tick = t;
    @(posedge clk);
    model_update(we, a, d, t);
    #5;
    chk({tag, " tc_pulse"}, {31'b0, tc_pulse}, {31'b0, m_tc});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rdexp(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step(1'b0, a, 8'h00, 1'b0, tag);
    chk({tag, " rdata"}, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  task automatic measure(input int period, input int exp, input string tag);
    int  n    = 0;
    bit  seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      step(1'b0, 2'd0, 8'h00, (i % period) == period - 1, tag);
      n++;
      if (tc_pulse) seen = 1;
    end
    chk({tag, " pulse spacing"}, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    m_run = 0; m_single = 0; m_fast = 0; m_tc = 0; m_full = 0; m_cnt = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0; slow_tick = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset ctrl", {24'b0, reg_rdata}, 32'h0);
    chk("R6 reset tc", {31'b0, tc_pulse}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: register map, unused bits and unused address
    rdexp(2'd1, 8'h00, "R1");
    rdexp(2'd2, 8'h00, "R1");
    wr(2'd1, 8'h05, "R1");
    wr(2'd2, 8'h00, "R1");
    rdexp(2'd1, 8'h05, "R1");
    wr(2'd3, 8'hFF, "R1");
    rdexp(2'd3, 8'h00, "R1");
    wr(2'd0, 8'hF8, "R1");
    rdexp(2'd0, 8'h00, "R1");

    // R3 and R5: single mode, fast source, N=5
    wr(2'd0, 8'h07, "R3");
    measure(1, 6, "R3");
    rdexp(2'd0, 8'h06, "R5");
    measure(1, 300, "R5");

    // R4: repeat mode, N=3
    wr(2'd1, 8'h03, "R4");
    wr(2'd0, 8'h05, "R4");
    measure(1, 4, "R4");
    measure(1, 4, "R4");
    wr(2'd0, 8'h04, "R4");

    // R2: slow source, tick every third cycle, N=2
    wr(2'd1, 8'h02, "R2");
    wr(2'd0, 8'h03, "R2");
    measure(3, 9, "R2");

    // R3: zero full count
    wr(2'd1, 8'h00, "R3");
    wr(2'd0, 8'h07, "R3");
    measure(1, 1, "R3");

    // R7: stop on the would-be terminal cycle, then restart
    wr(2'd1, 8'h03, "R7");
    wr(2'd0, 8'h05, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 8'h00, 1'b0, "R7");
    wr(2'd0, 8'h04, "R7");
    chk("R7 no pulse on stop", {31'b0, tc_pulse}, 32'h0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 8'h00, 1'b0, "R7");
    rdexp(2'd0, 8'h04, "R7");
    wr(2'd0, 8'h05, "R7");
    measure(1, 4, "R7");
    wr(2'd0, 8'h04, "R7");

    // R8: byte write while running applies at the next reload
    wr(2'd0, 8'h05, "R8");
    wr(2'd1, 8'h01, "R8");
    measure(1, 3, "R8");
    measure(1, 2, "R8");
    wr(2'd0, 8'h04, "R8");

    // R9: control rewrite with run set does not restart
    wr(2'd1, 8'h03, "R9");
    wr(2'd0, 8'h05, "R9");
    step(1'b0, 2'd0, 8'h00, 1'b0, "R9");
    step(1'b0, 2'd0, 8'h00, 1'b0, "R9");
    wr(2'd0, 8'h05, "R9");
    measure(1, 1, "R9");
    wr(2'd0, 8'h00, "R9");

    // R6: constrained random traffic against the bench model
    for (int i = 0; i < 4000; i++) begin
      logic       we;
      logic [1:0] a;
      logic [7:0] d;
      logic       t;
      we = ($urandom % 8) == 0;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (a == 2'd1) d = d & 8'h1F;
      if (a == 2'd2) d = (($urandom % 16) == 0) ? 8'h01 : 8'h00;
      t  = ($urandom % 3) == 0;
      step(we, a, d, t, "R6");
      if ((i % 16) == 15) begin
        logic [1:0] ra;
        ra = 2'($urandom % 4);
        step(1'b0, ra, 8'h00, 1'b0, "R6");
        chk("R1 random read", {24'b0, reg_rdata}, {24'b0, mread(ra)});
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule